// File: doc/BRIEF.md
# Virtual-Output-Queued Mesh Router

This block is one node of a two-dimensional mesh on chip. It has five ports: one local port and four neighbours. Each input port stores arriving flits in separate queues, one for every other port. The sender names the queue with a selector that travels with the flit. The queue therefore already fixes where the flit leaves, and the router needs no route-computation step and no channel-allocation step.

Each output has its own arbiter, which picks among the queue heads that target that output. In the same clock the crossbar moves the chosen head into the output register. A flit that meets no competition therefore spends one cycle in the switch after it is written into its queue.

Flow control uses credits in both directions. Each output holds one credit counter for each queue of the downstream node. The flit's top three bits name which downstream queue it will enter. When a flit leaves one of this router's queues, a credit pulse goes back to the upstream sender.

Top module: `voq_router`

## Requirements
- R1: After reset, `out_valid` and `crd_ret` are all zero, and every output holds 4 credits for each downstream queue.
- R2: A flit at input i with `in_qsel` = o (o ≠ i, o < 5) leaves only on output o, exactly once and unchanged. Flits from the same input to the same output leave in arrival order.
- R3: Each output grants at most one input per cycle and presents at most one flit per cycle.
- R4: A flit sampled at clock edge k, whose output is free and has credit, is on `out_valid`/`out_flit` after edge k+1.
- R5: Each output arbitrates round-robin. Search starts at the grant pointer, and after a grant the pointer moves to the input just past the winner. Right after reset the pointer is at input 0.
- R6: A flit's bits [15:13] name its downstream queue d. The flit is sent only while the output's counter for d is non-zero. A send decrements that counter and a `crd_in` pulse on bit o·5+d increments it. While credits stay withheld, at most 4 flits leave per downstream queue, and flow resumes when credits return.
- R7: When input i's queue for output o sends a flit, `crd_ret` bit i·5+o is high for one cycle. That cycle is the same cycle the flit appears on the output.
- R8: A flit whose `in_qsel` equals its own input index, or is 5 or more, is discarded. It produces no output and no credit pulse.
- R9: A queue accepts a write and a read in the same cycle. A queue holding 4 flits loses none of them while it waits for credit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 5 | Per-input flit strobe |
| in_qsel | input | 15 | Per-input queue selector, 3 bits each (target output) |
| in_flit | input | 80 | Per-input 16-bit flit |
| crd_ret | output | 25 | Credit pulse to upstream, bit i·5+o |
| out_valid | output | 5 | Per-output flit strobe |
| out_flit | output | 80 | Per-output 16-bit flit |
| crd_in | input | 25 | Credit pulse from downstream, bit o·5+d |

## Verification
A single isolated flit measures the bare switch latency and the credit pulse timing. Two inputs aimed at one output in the same cycle expose the grant order, and a second pair chosen to straddle the moved pointer separates true rotation from a fixed priority. Withholding downstream credits while one queue keeps sending shows that sending stops at exactly four and that the stalled queue fills without loss. A long random phase with credits held back at intervals drives simultaneous push and pop, and a scoreboard kept per input/output pair checks that each flit is delivered once and in order. Own-port and out-of-range selectors show that discarded flits stay invisible.

// File: rtl/voq_pkg.sv
`timescale 1ns/1ps
package voq_pkg;
  // round-robin: next search start is the port just past the winner
  function automatic int rr_next(int win, int n);
    return (win + 1) % n;
  endfunction

  // credit counter step: +1 on a returned credit, -1 on a send
  function automatic int crd_step(int c, bit inc, bit dec);
    return c + (inc ? 1 : 0) - (dec ? 1 : 0);
  endfunction
endpackage

// File: rtl/voq_fifo.sv
`timescale 1ns/1ps
module voq_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= bump(wp);
      if (pop)  rp <= bump(rp);
      cnt <= cnt + CW'(push) - CW'(pop);
    end
  end

  assign dout  = mem[rp];
  assign empty = (cnt == '0);
  assign full  = (cnt == CW'(DEPTH));
endmodule

// File: rtl/voq_rr_arb.sv
`timescale 1ns/1ps
module voq_rr_arb #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  import voq_pkg::*;
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [IW-1:0] ptr;
  logic [IW-1:0] win;
  logic          hit;

  always_comb begin
    gnt = '0;
    win = '0;
    hit = 1'b0;
    for (int k = 0; k < N; k++) begin
      if (!hit && req[(int'(ptr) + k) % N]) begin
        hit = 1'b1;
        win = IW'((int'(ptr) + k) % N);
        gnt[(int'(ptr) + k) % N] = 1'b1;
      end
    end
  end

  // every grant is a transfer (credit checked in the request)
  always_ff @(posedge clk) begin
    if (!rst_n)   ptr <= '0;
    else if (hit) ptr <= IW'(rr_next(int'(win), N));
  end
endmodule

// File: rtl/voq_crd_bank.sv
`timescale 1ns/1ps
module voq_crd_bank #(
  parameter int NDN   = 5,
  parameter int DEPTH = 4,
  parameter int SELW  = 3,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NDN-1:0]    ret,
  input  logic              take,
  input  logic [SELW-1:0]   take_sel,
  output logic [NDN-1:0]    avail,
  output logic [NDN*CW-1:0] cnt_flat
);
  import voq_pkg::*;

  for (genvar d = 0; d < NDN; d++) begin : g_ctr
    logic [CW-1:0] cnt;
    logic          dec;
    assign dec = take && (take_sel == SELW'(d));
    always_ff @(posedge clk) begin
      if (!rst_n) cnt <= CW'(DEPTH);
      else        cnt <= CW'(crd_step(int'(cnt), ret[d], dec));
    end
    assign avail[d] = (cnt != '0);
    assign cnt_flat[d*CW +: CW] = cnt;
  end
endmodule

// File: rtl/voq_router.sv
`timescale 1ns/1ps
module voq_router #(
  parameter int NPORT = 5,
  parameter int W     = 16,
  parameter int DEPTH = 4,
  localparam int SELW = $clog2(NPORT)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NPORT-1:0]       in_valid,
  input  logic [NPORT*SELW-1:0]  in_qsel,
  input  logic [NPORT*W-1:0]     in_flit,
  output logic [NPORT*NPORT-1:0] crd_ret,
  output logic [NPORT-1:0]       out_valid,
  output logic [NPORT*W-1:0]     out_flit,
  input  logic [NPORT*NPORT-1:0] crd_in
);
  localparam int NQ = NPORT * NPORT;
  localparam int CW = $clog2(DEPTH + 1);

  // queue-indexed (i*NPORT+o) and output-indexed (o*NPORT+i) event wires
  logic [NQ-1:0]         q_push, q_empty, q_full;
  logic [NQ*W-1:0]       head_flat;
  logic [NQ-1:0]         req_om, gnt_om;
  logic [NQ-1:0]         avail_flat;
  logic [NQ*CW-1:0]      cnt_flat;
  logic [NPORT-1:0]      xfer;
  logic [NPORT*W-1:0]    xdata;
  logic [NQ-1:0]         pop_io;

  function automatic logic crd_ok(input logic [NPORT-1:0] av, input logic [SELW-1:0] s);
    crd_ok = 1'b0;
    for (int d = 0; d < NPORT; d++)
      if (s == SELW'(d)) crd_ok = av[d];
  endfunction

  for (genvar i = 0; i < NPORT; i++) begin : g_in
    for (genvar o = 0; o < NPORT; o++) begin : g_out
      localparam int Q = i * NPORT + o;
      if (i != o) begin : g_q
        logic [SELW-1:0] dsel;
        assign q_push[Q] = in_valid[i] && (in_qsel[i*SELW +: SELW] == SELW'(o));
        voq_fifo #(.W(W), .DEPTH(DEPTH)) u_q (
          .clk   (clk),
          .rst_n (rst_n),
          .push  (q_push[Q]),
          .din   (in_flit[i*W +: W]),
          .pop   (pop_io[Q]),
          .dout  (head_flat[Q*W +: W]),
          .empty (q_empty[Q]),
          .full  (q_full[Q])
        );
        assign dsel = head_flat[Q*W + W - SELW +: SELW];
        assign req_om[o*NPORT + i] = !q_empty[Q] && crd_ok(avail_flat[o*NPORT +: NPORT], dsel);
      end else begin : g_none
        assign q_push[Q]            = 1'b0;
        assign q_empty[Q]           = 1'b1;
        assign q_full[Q]            = 1'b0;
        assign head_flat[Q*W +: W]  = '0;
        assign req_om[o*NPORT + i]  = 1'b0;
      end
      assign pop_io[Q] = gnt_om[o*NPORT + i];
    end
  end

  for (genvar o = 0; o < NPORT; o++) begin : g_port
    voq_rr_arb #(.N(NPORT)) u_arb (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (req_om[o*NPORT +: NPORT]),
      .gnt   (gnt_om[o*NPORT +: NPORT])
    );

    // crossbar column: AND-OR select of the granted queue head
    always_comb begin
      xdata[o*W +: W] = '0;
      for (int i = 0; i < NPORT; i++)
        if (gnt_om[o*NPORT + i]) xdata[o*W +: W] = xdata[o*W +: W] | head_flat[(i*NPORT + o)*W +: W];
    end
    assign xfer[o] = |gnt_om[o*NPORT +: NPORT];

    voq_crd_bank #(.NDN(NPORT), .DEPTH(DEPTH), .SELW(SELW)) u_crd (
      .clk      (clk),
      .rst_n    (rst_n),
      .ret      (crd_in[o*NPORT +: NPORT]),
      .take     (xfer[o]),
      .take_sel (xdata[o*W + W - SELW +: SELW]),
      .avail    (avail_flat[o*NPORT +: NPORT]),
      .cnt_flat (cnt_flat[o*NPORT*CW +: NPORT*CW])
    );

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        out_valid[o]      <= 1'b0;
        out_flit[o*W +: W] <= '0;
      end else begin
        out_valid[o] <= xfer[o];
        if (xfer[o]) out_flit[o*W +: W] <= xdata[o*W +: W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) crd_ret <= '0;
    else        crd_ret <= pop_io;
  end
endmodule

// File: rtl/voq_router_chk.sv
`timescale 1ns/1ps
module voq_router_chk #(
  parameter int NPORT = 5,
  parameter int DEPTH = 4,
  localparam int NQ   = NPORT * NPORT,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NPORT-1:0] out_valid,
  input logic [NQ-1:0]    crd_ret,
  input logic [NQ-1:0]    gnt_om,
  input logic [NQ-1:0]    q_push,
  input logic [NQ-1:0]    q_full,
  input logic [NQ*CW-1:0] cnt_flat
);
  for (genvar o = 0; o < NPORT; o++) begin : g_o
    a_r3_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt_om[o*NPORT +: NPORT]));
    a_r4_grant_to_out: assert property (@(posedge clk) disable iff (!rst_n)
      (|gnt_om[o*NPORT +: NPORT]) |=> out_valid[o]);
    a_r3_no_phantom: assert property (@(posedge clk) disable iff (!rst_n)
      !(|gnt_om[o*NPORT +: NPORT]) |=> !out_valid[o]);
    for (genvar i = 0; i < NPORT; i++) begin : g_i
      a_r7_credit_back: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_om[o*NPORT + i] |=> crd_ret[i*NPORT + o]);
    end
  end

  for (genvar q = 0; q < NQ; q++) begin : g_q
    a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      !(q_push[q] && q_full[q]));
    a_r6_credit_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_flat[q*CW +: CW] <= CW'(DEPTH));
  end
endmodule

bind voq_router voq_router_chk #(.NPORT(NPORT), .DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .out_valid (out_valid),
  .crd_ret   (crd_ret),
  .gnt_om    (gnt_om),
  .q_push    (q_push),
  .q_full    (q_full),
  .cnt_flat  (cnt_flat)
);

// File: tb/sim_voq_router.sv
`timescale 1ns/1ps
module sim_voq_router;
  localparam int N = 5;
  localparam int W = 16;

  logic           clk = 1'b0;
  logic           rst_n;
  logic [N-1:0]   in_valid;
  logic [N*3-1:0] in_qsel;
  logic [N*W-1:0] in_flit;
  logic [N*N-1:0] crd_ret;
  logic [N-1:0]   out_valid;
  logic [N*W-1:0] out_flit;
  logic [N*N-1:0] crd_in;

  always #2.5 clk = ~clk;

  voq_router u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_qsel(in_qsel),
    .in_flit(in_flit), .crd_ret(crd_ret), .out_valid(out_valid),
    .out_flit(out_flit), .crd_in(crd_in)
  );

  int passed = 0;
  int total  = 0;
  logic [W-1:0] expq [N*N][$];
  int upcred [N][N];
  int pend   [N][N];
  int rxcnt  [N];
  int seqn   [N];
  bit hold;
  bit done;

  task automatic chk(bit ok, string msg);
    total++;
    if (ok) passed++;
    else $display("FAIL %s", msg);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", passed, total);
    $finish;
  endtask

  // flit format: [15:13] downstream queue, [12:10] source input, [9:0] sequence
  task automatic drive(int i, int o, int d);
    logic [W-1:0] f;
    f = {3'(d), 3'(i), 10'(seqn[i])};
    seqn[i]++;
    in_valid[i]          = 1'b1;
    in_qsel[i*3 +: 3]    = 3'(o);
    in_flit[i*W +: W]    = f;
    if (o != i && o < N) begin
      expq[i*N + o].push_back(f);
      upcred[i][o]--;
    end
  endtask

  task automatic tick;
    @(negedge clk);
    in_valid = '0;
  endtask

  // monitor / scoreboard / downstream and upstream credit models
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      crd_in = '0;
      for (int o = 0; o < N; o++) begin
        if (out_valid[o]) begin
          logic [W-1:0] f, e;
          int src, dq;
          f   = out_flit[o*W +: W];
          src = int'(f[12:10]);
          dq  = int'(f[15:13]);
          if (src >= N || expq[src*N + o].size() == 0)
            chk(1'b0, $sformatf("R2 out%0d got %h expected none", o, f));
          else begin
            e = expq[src*N + o].pop_front();
            chk(f == e, $sformatf("R2 out%0d got %h expected %h", o, f, e));
          end
          rxcnt[o]++;
          if (dq < N) pend[o][dq]++;
        end
      end
      for (int i = 0; i < N; i++)
        for (int o = 0; o < N; o++)
          if (crd_ret[i*N + o]) upcred[i][o]++;
      if (!hold)
        for (int o = 0; o < N; o++)
          for (int d = 0; d < N; d++)
            if (pend[o][d] > 0) begin
              crd_in[o*N + d] = 1'b1;
              pend[o][d]--;
            end
    end
  end

  initial begin
    #750us;
    if (!done) begin
      total++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    int base;
    int sent;
    bit quiet;
    done = 1'b0;
    hold = 1'b0;
    rst_n = 1'b0;
    in_valid = '0; in_qsel = '0; in_flit = '0; crd_in = '0;
    for (int i = 0; i < N; i++) begin
      rxcnt[i] = 0; seqn[i] = 0;
      for (int o = 0; o < N; o++) begin upcred[i][o] = 4; pend[i][o] = 0; end
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();
    chk(out_valid == '0 && crd_ret == '0,
        $sformatf("R1 reset outputs got %h/%h expected 0/0", out_valid, crd_ret));

    // R4 latency and R7 credit pulse timing
    tick(); drive(0, 1, 0);
    tick();
    chk(out_valid[1] == 1'b0, $sformatf("R4 early out1 got %b expected 0", out_valid[1]));
    tick();
    chk(out_valid[1] == 1'b1, $sformatf("R4 out1 after one switch cycle got %b expected 1", out_valid[1]));
    chk(crd_ret[0*N + 1] == 1'b1, $sformatf("R7 crd_ret bit1 got %b expected 1", crd_ret[1]));
    tick();
    chk(crd_ret == '0, $sformatf("R7 pulse width got %h expected 0", crd_ret));

    // R5 round robin: pointer at 1 now; inputs 0 and 2 -> 2 wins? search from 1 -> 2 first
    tick(); drive(0, 1, 1); drive(2, 1, 1);
    tick(); tick();
    chk(out_valid[1] && out_flit[1*W+10 +: 3] == 3'd2,
        $sformatf("R5 first winner got %0d expected 2", out_flit[1*W+10 +: 3]));
    tick();
    chk(out_valid[1] && out_flit[1*W+10 +: 3] == 3'd0,
        $sformatf("R5 second winner got %0d expected 0", out_flit[1*W+10 +: 3]));
    // pointer now 1: inputs 0 and 3 -> 3 first
    tick(); drive(0, 1, 3); drive(3, 1, 3);
    tick(); tick();
    chk(out_valid[1] && out_flit[1*W+10 +: 3] == 3'd3,
        $sformatf("R5 rotated winner got %0d expected 3", out_flit[1*W+10 +: 3]));
    tick();
    chk(out_valid[1] && out_flit[1*W+10 +: 3] == 3'd0,
        $sformatf("R3 second grant got %0d expected 0", out_flit[1*W+10 +: 3]));

    // R8 discard own-port and out-of-range selectors
    tick(); drive(1, 1, 0); drive(3, 7, 0);
    quiet = 1'b1;
    repeat (4) begin
      tick();
      if (out_valid != '0 || crd_ret != '0) quiet = 1'b0;
    end
    chk(quiet, $sformatf("R8 discarded flit visible got %b expected 1", quiet));

    // R6 credit stall and R9 full queue
    hold = 1'b1;
    base = rxcnt[1];
    sent = 0;
    for (int c = 0; c < 40 && sent < 8; c++) begin
      tick();
      if (upcred[0][1] > 0) begin drive(0, 1, 2); sent++; end
    end
    repeat (10) tick();
    chk(rxcnt[1] - base == 4, $sformatf("R6 sent under held credit got %0d expected 4", rxcnt[1] - base));
    chk(expq[0*N + 1].size() == 4, $sformatf("R9 stalled queue held got %0d expected 4", expq[1].size()));
    hold = 1'b0;
    for (int c = 0; c < 60 && sent < 12; c++) begin
      tick();
      if (upcred[0][1] > 0) begin drive(0, 1, 2); sent++; end
    end
    repeat (20) tick();
    chk(rxcnt[1] - base == 12, $sformatf("R6 resumed total got %0d expected 12", rxcnt[1] - base));

    // random traffic, R2/R9 through the scoreboard
    for (int cyc = 0; cyc < 3000; cyc++) begin
      tick();
      hold = ($urandom % 4) == 0;
      for (int i = 0; i < N; i++) begin
        if ($urandom % 2) begin
          int o;
          o = int'($urandom % N);
          if (o != i && upcred[i][o] > 0) drive(i, o, int'($urandom % N));
        end
      end
    end
    hold = 1'b0;
    repeat (60) tick();
    for (int q = 0; q < N*N; q++)
      chk(expq[q].size() == 0, $sformatf("R2 pair %0d left got %0d expected 0", q, expq[q].size()));
    done = 1'b1;
    summary();
  end
endmodule